// File: doc/BRIEF.md
# Maskable Interrupt Status Aggregator

This block gathers single-cycle event pulses from 48 sources, organised as six groups of eight. It holds each one in a sticky status bit that a processor reads back through a small register port. Each group has an 8-bit mask register in which a 1 blocks the matching source and a 0 lets it through.

A group summary register shows which groups hold at least one pending unmasked status bit. One active-high interrupt line asserts while any summary bit is set.

A global visibility control chooses how masked sources are handled:
- When it is off, masked events are dropped and never latched.
- When it is on, masked events are latched and readable in the status registers.

In both cases a masked source never reaches the summary register or the interrupt line.

The interrupt line comes from a two-state machine:
- State `IRQ_IDLE`: the line is low.
- State `IRQ_ASSERTED`: the line is high.
- Transition `IDLE->ASSERTED` is taken when any group has a pending unmasked bit.
- Transition `ASSERTED->IDLE` is taken when none does.
- Each state holds itself while its exit condition is false.

Register map (5-bit offset, 8-bit data):
- Offsets 0..5: mask register of groups 0..5.
- Offsets 8..13: status register of groups 0..5.
- Offset 16: group summary.
- Offset 17: control, with bit 0 as the visibility bit.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every mask register reads 0xFF, every status register reads 0x00, the summary and control registers read 0x00, and `irq_o` is low.
- R2: A source whose mask bit is 0 latches its event, and the event raises `irq_o`.
- R3: A status bit whose mask bit is 1 never raises `irq_o`, whatever the visibility setting.
- R4: Summary bit n (offset 16) is 1 exactly when status group n has a set bit whose mask bit is 0. Summary bits 6 and 7 read 0.
- R5: With control bit 0 cleared, an event on a masked source is not latched, so its status register reads 0x00.
- R6: With control bit 0 set, an event on a masked source is latched and reads back in its status register, while `irq_o` and the summary stay low.
- R7: Status bits are sticky and accumulate. A read of a status offset returns its value and clears the register on that clock edge, except that an event arriving in the same cycle as the read stays set.
- R8: `irq_o` is registered. It rises one clock after a qualifying status bit is latched, and it falls one clock after the last pending unmasked bit is cleared.
- R9: In visible mode, clearing the mask bit of an already set status bit raises `irq_o` one clock after the mask register takes the write.
- R10: The register map and its access rules are as follows.
  - Mask registers sit at offsets 0..5, status registers at offsets 8..13, the summary at offset 16 and the control register at offset 17.
  - Control bit 0 is the visibility bit, and its other bits read 0.
  - Writes to status or summary offsets have no effect.
  - Unmapped offsets read 0x00.
  - `rdata_o` is a combinational function of `addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 48 | Event pulses; bit 8*g+b is source b of group g |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears an addressed status register) |
| addr_i | input | 5 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
All 48 sources are pulsed one at a time in three setups:
- Unmasked with visibility off. This shows that each source lands in its own group and bit, reaches the summary, and raises the interrupt with one clock of latency.
- Masked with visibility off. This shows that masked events are dropped.
- Masked with visibility on. This shows that masked events are latched but stay off the summary and the interrupt.

Directed cases cover the rest:
- An event arriving in the same cycle as a read.
- Accumulation of several events in one group.
- Unmasking a bit that is already set.
- Two groups pending at once.
- Writes to read-only offsets.
- Unmapped offsets.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int unsigned REG_W     = 8;
    localparam int unsigned ADDR_W    = 5;
    localparam int unsigned MASK_BASE = 0;
    localparam int unsigned STAT_BASE = 8;
    localparam int unsigned SUM_ADDR  = 16;
    localparam int unsigned CTRL_ADDR = 17;

    typedef enum logic {
        IRQ_IDLE     = 1'b0,
        IRQ_ASSERTED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/irq_status_group.sv
module irq_status_group #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vis_i,
    input  logic [W-1:0] evt_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         stat_rd_i,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] stat_o,
    output logic         pend_o
);
    logic [W-1:0] mask_q;
    logic [W-1:0] stat_q;
    logic [W-1:0] latch_in;

    // Masked events are only admitted in visible mode
    always_comb latch_in = vis_i ? evt_i : (evt_i & ~mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= '1;
        else if (mask_we_i)
            mask_q <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= (stat_rd_i ? '0 : stat_q) | latch_in;
    end

    assign mask_o = mask_q;
    assign stat_o = stat_q;
    assign pend_o = |(stat_q & ~mask_q);

    AST_HIDDEN_NOT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !vis_i |=> ((stat_q & ~$past(stat_q) & $past(mask_q)) == '0)); // R5
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd_i |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && evt_i == '0) |=> (stat_q == '0)); // R7
    AST_EVENT_SURVIVES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !mask_q[0] && evt_i[0]) |=> stat_q[0]); // R7
endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend_i,
    output logic irq_o
);
    irq_state_t state_q;
    irq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:     if (any_pend_i)  state_d = IRQ_ASSERTED;
            IRQ_ASSERTED: if (!any_pend_i) state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= IRQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb irq_o = (state_q == IRQ_ASSERTED);

    AST_IRQ_RISES_ON_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend_i |=> irq_o); // R8
    AST_IRQ_FALLS_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pend_i |=> !irq_o); // R8
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_GROUPS*REG_W-1:0]   evt_i,
    input  logic                          wr_en_i,
    input  logic                          rd_en_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [REG_W-1:0]              wdata_i,
    output logic [REG_W-1:0]              rdata_o,
    output logic                          irq_o
);
    localparam logic [ADDR_W-1:0] SUM_OFS  = ADDR_W'(SUM_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(CTRL_ADDR);

    logic [REG_W-1:0]      mask_arr [NUM_GROUPS];
    logic [REG_W-1:0]      stat_arr [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] pend;
    logic [NUM_GROUPS-1:0] mask_we;
    logic [NUM_GROUPS-1:0] stat_rd;
    logic [REG_W-1:0]      summary;
    logic                  vis_q;
    logic                  any_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            vis_q <= 1'b0;
        else if (wr_en_i && addr_i == CTRL_OFS)
            vis_q <= wdata_i[0];
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign mask_we[g] = wr_en_i && (addr_i == ADDR_W'(MASK_BASE + g));
        assign stat_rd[g] = rd_en_i && (addr_i == ADDR_W'(STAT_BASE + g));

        irq_status_group #(.W(REG_W)) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .vis_i     (vis_q),
            .evt_i     (evt_i[g*REG_W +: REG_W]),
            .mask_we_i (mask_we[g]),
            .wdata_i   (wdata_i),
            .stat_rd_i (stat_rd[g]),
            .mask_o    (mask_arr[g]),
            .stat_o    (stat_arr[g]),
            .pend_o    (pend[g])
        );
    end

    always_comb begin
        summary = '0;
        summary[NUM_GROUPS-1:0] = pend;
    end

    assign any_pend = |pend;

    always_comb begin
        rdata_o = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (addr_i == ADDR_W'(MASK_BASE + g)) rdata_o = mask_arr[g];
            if (addr_i == ADDR_W'(STAT_BASE + g)) rdata_o = stat_arr[g];
        end
        if (addr_i == SUM_OFS)  rdata_o = summary;
        if (addr_i == CTRL_OFS) rdata_o = {{(REG_W-1){1'b0}}, vis_q};
    end

    irq_out_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_pend_i (any_pend),
        .irq_o      (irq_o)
    );

    AST_IRQ_NEEDS_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(summary != '0)); // R3
    AST_MASKED_GRP0_NO_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_arr[0] == '1) |-> !summary[0]); // R4
    AST_UNMASK_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (vis_q && mask_we[0] && ((stat_arr[0] & ~wdata_i) != '0)) |=> ##1 irq_o); // R9
endmodule

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
    localparam int NG = 6;
    localparam int W  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NG*W-1:0] evt = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [4:0]    addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          irq;
    int            checks = 0;
    int            fails = 0;
    bit            reported = 1'b0;

    always #2.5 clk = ~clk;

    irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; #1 v = rdata;
    endtask

    task automatic pulse(input int g, input int b);
        @(negedge clk); evt[g*W+b] = 1'b1;
        @(negedge clk); evt = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int g = 0; g < NG; g++) begin
            peek(5'(g), v);     chk("R1 mask reset", v, 8'hFF);
            peek(5'(8 + g), v); chk("R1 status reset", v, 8'h00);
        end
        peek(5'd16, v); chk("R1 summary reset", v, 8'h00);
        peek(5'd17, v); chk("R1 control reset", v, 8'h00);
        chk("R1 irq reset", {7'd0, irq}, 8'h00);

        // R10 unmapped offsets
        peek(5'd6, v);  chk("R10 unmapped 6", v, 8'h00);
        peek(5'd14, v); chk("R10 unmapped 14", v, 8'h00);
        peek(5'd20, v); chk("R10 unmapped 20", v, 8'h00);

        // Sweep A: unmasked, visibility off
        for (int g = 0; g < NG; g++) begin
            wr(5'(g), 8'h00);
            for (int b = 0; b < W; b++) begin
                pulse(g, b);
                #1 chk("R8 irq latency low", {7'd0, irq}, 8'h00);
                peek(5'd16, v); chk("R4 summary one group", v, 8'(1 << g));
                #1 chk("R2 irq raised", {7'd0, irq}, 8'h01);
                rd(5'(8 + g), v); chk("R7 status read value", v, 8'(1 << b));
                peek(5'(8 + g), v); chk("R7 cleared by read", v, 8'h00);
                #1 chk("R8 irq falls", {7'd0, irq}, 8'h00);
            end
            wr(5'(g), 8'hFF);
        end

        // Sweep B: masked, visibility off
        for (int g = 0; g < NG; g++) begin
            for (int b = 0; b < W; b++) begin
                pulse(g, b);
                @(negedge clk); #1 chk("R3 masked no irq", {7'd0, irq}, 8'h00);
                peek(5'(8 + g), v); chk("R5 masked dropped", v, 8'h00);
            end
        end

        // Sweep C: masked, visibility on
        wr(5'd17, 8'h01);
        for (int g = 0; g < NG; g++) begin
            for (int b = 0; b < W; b++) begin
                pulse(g, b);
                @(negedge clk); #1 chk("R6 visible no irq", {7'd0, irq}, 8'h00);
                peek(5'd16, v); chk("R4 masked not in summary", v, 8'h00);
                rd(5'(8 + g), v); chk("R6 visible latched", v, 8'(1 << b));
            end
        end

        // R9 unmask an already-set bit
        pulse(2, 5);
        peek(5'd10, v); chk("R9 status set", v, 8'h20);
        wr(5'd2, 8'hDF);
        #1 chk("R9 irq not yet", {7'd0, irq}, 8'h00);
        @(negedge clk); #1 chk("R9 irq after unmask", {7'd0, irq}, 8'h01);
        rd(5'd10, v);
        wr(5'd2, 8'hFF);
        @(negedge clk); #1 chk("R8 irq idle after clear", {7'd0, irq}, 8'h00);

        // R10 control register access
        wr(5'd17, 8'hFF);
        peek(5'd17, v); chk("R10 control bit0 only", v, 8'h01);
        wr(5'd17, 8'h00);
        peek(5'd17, v); chk("R10 control cleared", v, 8'h00);

        // R7 event during read survives, accumulation
        wr(5'd1, 8'h00);
        pulse(1, 0);
        @(negedge clk); addr = 5'd9; rd_en = 1'b1; evt[1*W+3] = 1'b1;
        #1 chk("R7 read returns old", rdata, 8'h01);
        @(negedge clk); rd_en = 1'b0; evt = '0;
        peek(5'd9, v); chk("R7 same-cycle event kept", v, 8'h08);
        rd(5'd9, v);
        pulse(1, 1);
        pulse(1, 6);
        rd(5'd9, v); chk("R7 sticky accumulate", v, 8'h42);

        // R10 writes to read-only offsets ignored
        pulse(1, 2);
        wr(5'd9, 8'h00);
        peek(5'd9, v); chk("R10 status write ignored", v, 8'h04);
        wr(5'd16, 8'h00);
        peek(5'd16, v); chk("R10 summary write ignored", v, 8'h02);
        rd(5'd9, v);
        wr(5'd1, 8'hFF);

        // R4 two groups pending
        wr(5'd0, 8'h00);
        wr(5'd5, 8'h00);
        pulse(0, 7);
        pulse(5, 0);
        peek(5'd16, v); chk("R4 two groups", v, 8'h21);
        chk("R2 irq two groups", {7'd0, irq}, 8'h01);
        rd(5'd8, v); chk("R7 group0 read", v, 8'h80);
        peek(5'd16, v); chk("R4 one group left", v, 8'h20);
        rd(5'd13, v); chk("R7 group5 read", v, 8'h01);
        @(negedge clk); #1 chk("R8 irq low after both", {7'd0, irq}, 8'h00);

        report();
        $finish;
    end
endmodule